// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds a small bank of hardware semaphore flags that two agents, a left port and a right port, share to coordinate ownership of a common resource. Each port reaches the flags through a dedicated semaphore select. It does not use the memory enable. To claim a flag, a port writes to it. To find out whether the claim succeeded, the port reads the flag back.

Eight flags are indexed by a 3-bit flag index. A write with the data bit at 0 asks for a flag, and a write with the data bit at 1 gives it up. A read returns 0 on every data line to the port that owns the flag, and 1 on every data line otherwise. The read result lands in an output register and stays there until that port's next read. A write from the other port in the same cycle therefore cannot disturb the value being returned.

When both ports ask for one flag together, the left port wins. A request made against a flag the other port already holds is remembered. When the holder releases the flag, ownership passes straight to the waiting port.

Top module: `semBank`

## Requirements
- R1: After reset every flag is free, and both read-data outputs are all ones.
- R2: A read is a cycle with semaphore select and read enable high and write enable low. Its result appears in the next cycle on every data bit: all 0 if the reading port owns the indexed flag, all 1 otherwise.
- R3: A read samples flag state from before any write in the same cycle. The read-data output holds its value until that port's next read.
- R4: A flag is never owned by both ports at once.
- R5: A write with semaphore select, write enable and data bit 0 at 0 grants a free flag to the writer. A read issued in the next cycle shows the grant.
- R6: If both ports ask for the same free flag in one cycle, the left port gets it and the right port's request stays pending.
- R7: A request against a flag owned by the other port is held pending. When the owner releases, the flag passes to the waiting port.
- R8: A release (data bit 0 at 1) by the owner with no waiter frees the flag. A release by a non-owner withdraws its pending request and leaves the owner unchanged.
- R9: Reads and writes with semaphore select low have no effect on flags or read data.
- R10: The flags are independent. Each port's flag index selects one of eight flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| semSelL | input | 1 | Left semaphore select |
| wrEnL | input | 1 | Left write enable |
| rdEnL | input | 1 | Left read (output) enable |
| addrL | input | 3 | Left flag index |
| wrBitL | input | 1 | Left write data bit (0 request, 1 release) |
| rdDataL | output | DATA_W | Left registered read data |
| semSelR | input | 1 | Right semaphore select |
| wrEnR | input | 1 | Right write enable |
| rdEnR | input | 1 | Right read (output) enable |
| addrR | input | 3 | Right flag index |
| wrBitR | input | 1 | Right write data bit (0 request, 1 release) |
| rdDataR | output | DATA_W | Right registered read data |

## Verification
The assertions assume that a port never reads and writes in the same cycle. A cycle with write enable high counts as a write only. The grant and release properties also assume that the flag index stays valid while select is high. The directed stimulus drives at most one command per port per cycle. It deasserts every select between accesses, so each read and write occupies exactly one clock.

// File: rtl/semBankPkg.sv
`timescale 1ns/1ps
package semBankPkg;
  localparam int SEM_IDX_W = 3;
  localparam int SEM_FLAGS = 1 << SEM_IDX_W;

  typedef enum logic [1:0] {
    SEM_FREE  = 2'b00,
    SEM_LEFT  = 2'b01,
    SEM_RIGHT = 2'b10
  } semOwner_e;

  // strobes from the control decode to the flag datapath, one per port
  typedef struct packed {
    logic                 req;
    logic                 rel;
    logic                 cap;
    logic [SEM_IDX_W-1:0] idx;
  } semCmd_t;
endpackage

// File: rtl/semBankCtrl.sv
`timescale 1ns/1ps
module semBankCtrl
  import semBankPkg::*;
(
  input  logic                 semSel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [SEM_IDX_W-1:0] addr,
  input  logic                 wrBit,
  output semCmd_t              cmd
);
  always_comb begin
    cmd.req = semSel & wrEn & ~wrBit;
    cmd.rel = semSel & wrEn & wrBit;
    cmd.cap = semSel & rdEn & ~wrEn;
    cmd.idx = addr;
  end
endmodule

// File: rtl/semBankDatapath.sv
`timescale 1ns/1ps
module semBankDatapath
  import semBankPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  semCmd_t              cmdL,
  input  semCmd_t              cmdR,
  output logic [DATA_W-1:0]    rdDataL,
  output logic [DATA_W-1:0]    rdDataR,
  output logic [SEM_FLAGS-1:0] ownL,
  output logic [SEM_FLAGS-1:0] ownR
);
  for (genvar f = 0; f < SEM_FLAGS; f++) begin : gFlag
    semOwner_e ownerQ, ownerD;
    logic pendLQ, pendRQ, pendLD, pendRD;
    logic reqL, relL, reqR, relR, waitL, waitR;

    always_comb begin
      reqL  = cmdL.req && (cmdL.idx == SEM_IDX_W'(f));
      relL  = cmdL.rel && (cmdL.idx == SEM_IDX_W'(f));
      reqR  = cmdR.req && (cmdR.idx == SEM_IDX_W'(f));
      relR  = cmdR.rel && (cmdR.idx == SEM_IDX_W'(f));
      waitL = (pendLQ | reqL) & ~relL;
      waitR = (pendRQ | reqR) & ~relR;
      ownerD = ownerQ;
      pendLD = waitL;
      pendRD = waitR;
      case (ownerQ)
        SEM_FREE: begin
          if (reqL) begin
            ownerD = SEM_LEFT;
            pendLD = 1'b0;
          end else if (reqR) begin
            ownerD = SEM_RIGHT;
            pendRD = 1'b0;
          end
        end
        SEM_LEFT: begin
          pendLD = 1'b0;
          if (relL) begin
            if (waitR) begin
              ownerD = SEM_RIGHT;
              pendRD = 1'b0;
            end else begin
              ownerD = SEM_FREE;
            end
          end
        end
        SEM_RIGHT: begin
          pendRD = 1'b0;
          if (relR) begin
            if (waitL) begin
              ownerD = SEM_LEFT;
              pendLD = 1'b0;
            end else begin
              ownerD = SEM_FREE;
            end
          end
        end
        default: begin
          ownerD = SEM_FREE;
          pendLD = 1'b0;
          pendRD = 1'b0;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ownerQ <= SEM_FREE;
        pendLQ <= 1'b0;
        pendRQ <= 1'b0;
      end else begin
        ownerQ <= ownerD;
        pendLQ <= pendLD;
        pendRQ <= pendRD;
      end
    end

    assign ownL[f] = (ownerQ == SEM_LEFT);
    assign ownR[f] = (ownerQ == SEM_RIGHT);
  end

  // snapshot registers: sample state before this cycle's updates
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataL <= '1;
      rdDataR <= '1;
    end else begin
      if (cmdL.cap) rdDataL <= {DATA_W{~ownL[cmdL.idx]}};
      if (cmdR.cap) rdDataR <= {DATA_W{~ownR[cmdR.idx]}};
    end
  end
endmodule

// File: rtl/semBank.sv
`timescale 1ns/1ps
module semBank
  import semBankPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 semSelL,
  input  logic                 wrEnL,
  input  logic                 rdEnL,
  input  logic [SEM_IDX_W-1:0] addrL,
  input  logic                 wrBitL,
  output logic [DATA_W-1:0]    rdDataL,
  input  logic                 semSelR,
  input  logic                 wrEnR,
  input  logic                 rdEnR,
  input  logic [SEM_IDX_W-1:0] addrR,
  input  logic                 wrBitR,
  output logic [DATA_W-1:0]    rdDataR
);
  semCmd_t cmdL, cmdR;
  logic [SEM_FLAGS-1:0] ownL, ownR;

  semBankCtrl uCtrlL (.semSel(semSelL), .wrEn(wrEnL), .rdEn(rdEnL),
                      .addr(addrL), .wrBit(wrBitL), .cmd(cmdL));
  semBankCtrl uCtrlR (.semSel(semSelR), .wrEn(wrEnR), .rdEn(rdEnR),
                      .addr(addrR), .wrBit(wrBitR), .cmd(cmdR));

  semBankDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cmdL(cmdL), .cmdR(cmdR),
    .rdDataL(rdDataL), .rdDataR(rdDataR), .ownL(ownL), .ownR(ownR)
  );
endmodule

// File: rtl/semBankChk.sv
`timescale 1ns/1ps
module semBankChk
  import semBankPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 semSelL,
  input logic                 wrEnL,
  input logic                 rdEnL,
  input logic [SEM_IDX_W-1:0] addrL,
  input logic                 wrBitL,
  input logic [DATA_W-1:0]    rdDataL,
  input logic                 semSelR,
  input logic                 wrEnR,
  input logic                 rdEnR,
  input logic [SEM_IDX_W-1:0] addrR,
  input logic                 wrBitR,
  input logic [DATA_W-1:0]    rdDataR,
  input logic [SEM_FLAGS-1:0] ownL,
  input logic [SEM_FLAGS-1:0] ownR
);
  logic rdL, rdR, reqL, reqR, relL;
  assign rdL  = semSelL && rdEnL && !wrEnL;
  assign rdR  = semSelR && rdEnR && !wrEnR;
  assign reqL = semSelL && wrEnL && !wrBitL;
  assign reqR = semSelR && wrEnR && !wrBitR;
  assign relL = semSelL && wrEnL && wrBitL;

  // R4
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (ownL & ownR) == '0);

  // R2
  a_r2_read_left: assert property (@(posedge clk) disable iff (!rstN)
    rdL |=> rdDataL == {DATA_W{!$past(ownL[addrL])}});

  // R2
  a_r2_read_right: assert property (@(posedge clk) disable iff (!rstN)
    rdR |=> rdDataR == {DATA_W{!$past(ownR[addrR])}});

  // R3
  a_r3_hold_left: assert property (@(posedge clk) disable iff (!rstN)
    !rdL |=> $stable(rdDataL));

  // R3
  a_r3_hold_right: assert property (@(posedge clk) disable iff (!rstN)
    !rdR |=> $stable(rdDataR));

  // R5
  a_r5_grant_free: assert property (@(posedge clk) disable iff (!rstN)
    reqL && !ownL[addrL] && !ownR[addrL] |=> ownL[$past(addrL)]);

  // R6
  a_r6_left_wins: assert property (@(posedge clk) disable iff (!rstN)
    reqL && reqR && (addrL == addrR) && !ownL[addrL] && !ownR[addrL]
      |=> !ownR[$past(addrR)]);

  // R8
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    relL && ownL[addrL] |=> !ownL[$past(addrL)]);
endmodule

bind semBank semBankChk #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_semBank.sv
`timescale 1ns/1ps
module tb_semBank;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic semSelL = 0, wrEnL = 0, rdEnL = 0, wrBitL = 0;
  logic semSelR = 0, wrEnR = 0, rdEnR = 0, wrBitR = 0;
  logic [2:0] addrL = '0, addrR = '0;
  logic [DW-1:0] rdDataL, rdDataR;
  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  semBank #(.DATA_W(DW)) dut (.*);

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    semSelL = 0; wrEnL = 0; rdEnL = 0; wrBitL = 0;
    semSelR = 0; wrEnR = 0; rdEnR = 0; wrBitR = 0;
  endtask

  // port 0 = left, 1 = right
  task automatic wr(int p, int idx, logic b, logic sel = 1'b1);
    @(negedge clk);
    if (p == 0) begin semSelL = sel; wrEnL = 1; addrL = 3'(idx); wrBitL = b; end
    else        begin semSelR = sel; wrEnR = 1; addrR = 3'(idx); wrBitR = b; end
    @(negedge clk);
    idle();
  endtask

  task automatic rdChk(int p, int idx, logic expBit, string tag);
    @(negedge clk);
    if (p == 0) begin semSelL = 1; rdEnL = 1; addrL = 3'(idx); end
    else        begin semSelR = 1; rdEnR = 1; addrR = 3'(idx); end
    @(negedge clk);
    idle();
    chk(tag, (p == 0) ? rdDataL : rdDataR, {DW{expBit}});
  endtask

  task automatic tReset();
    chk("R1 left data", rdDataL, '1);
    chk("R1 right data", rdDataR, '1);
    for (int i = 0; i < 8; i++) begin
      rdChk(0, i, 1'b1, "R1 left flag free");
      rdChk(1, i, 1'b1, "R1 right flag free");
    end
  endtask

  task automatic tGrant();
    wr(0, 3, 1'b0);
    rdChk(0, 3, 1'b0, "R5 R2 left owns");
    rdChk(1, 3, 1'b1, "R2 right not owner");
  endtask

  task automatic tPending();
    wr(1, 3, 1'b0);
    rdChk(1, 3, 1'b1, "R7 right pending");
    rdChk(0, 3, 1'b0, "R7 left still owns");
    wr(0, 3, 1'b1);
    rdChk(1, 3, 1'b0, "R7 handoff right");
    rdChk(0, 3, 1'b1, "R7 left gave up");
  endtask

  task automatic tRelease();
    wr(1, 3, 1'b1);
    rdChk(1, 3, 1'b1, "R8 freed right");
    rdChk(0, 3, 1'b1, "R8 freed left");
    wr(0, 5, 1'b0);
    wr(1, 5, 1'b0);
    wr(1, 5, 1'b1);
    rdChk(0, 5, 1'b0, "R8 withdraw keeps owner");
    wr(0, 5, 1'b1);
    rdChk(1, 5, 1'b1, "R8 withdrawn not granted");
  endtask

  task automatic tTie();
    @(negedge clk);
    semSelL = 1; wrEnL = 1; wrBitL = 0; addrL = 3'd1;
    semSelR = 1; wrEnR = 1; wrBitR = 0; addrR = 3'd1;
    @(negedge clk);
    idle();
    rdChk(0, 1, 1'b0, "R6 left wins");
    rdChk(1, 1, 1'b1, "R6 right loses");
    wr(0, 1, 1'b1);
    rdChk(1, 1, 1'b0, "R6 right kept pending");
    wr(1, 1, 1'b1);
  endtask

  task automatic tSnapshot();
    @(negedge clk);
    semSelL = 1; wrEnL = 1; wrBitL = 0; addrL = 3'd6;
    semSelR = 1; rdEnR = 1; addrR = 3'd6;
    @(negedge clk);
    idle();
    chk("R3 read before write", rdDataR, '1);
    rdChk(0, 6, 1'b0, "R3 left owns six");
    wr(0, 6, 1'b1);
    repeat (3) @(negedge clk);
    chk("R3 left data held", rdDataL, '0);
  endtask

  task automatic tNoSelect();
    wr(0, 4, 1'b0, 1'b0);
    wr(1, 4, 1'b0);
    rdChk(1, 4, 1'b0, "R9 unselected write ignored");
    @(negedge clk);
    semSelR = 0; rdEnR = 1; addrR = 3'd2;
    @(negedge clk);
    idle();
    chk("R9 unselected read ignored", rdDataR, '0);
    wr(1, 4, 1'b1);
  endtask

  task automatic tIndep();
    wr(0, 0, 1'b0);
    wr(1, 7, 1'b0);
    rdChk(0, 0, 1'b0, "R10 left flag0");
    rdChk(0, 7, 1'b1, "R10 left flag7");
    rdChk(1, 7, 1'b0, "R10 right flag7");
    rdChk(1, 0, 1'b1, "R10 right flag0");
    rdChk(1, 2, 1'b1, "R10 other flag free");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tGrant();
    tPending();
    tRelease();
    tTie();
    tSnapshot();
    tNoSelect();
    tIndep();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule